// File: doc/BRIEF.md
# Serial Flash Boot Image Locator

This block runs at power-up, before any processor code exists. It finds where a boot image sits in a serial NOR flash. When started, it drives an SPI master interface in mode 0. It probes a fixed set of sector starts, one chip-select window per probe. Each probe sends the read opcode and the sector's byte address, then clocks in one 32-bit header word that holds the image length.

A sector counts as holding an image when that length word is neither all zeros nor all ones. The block trusts nothing else about the contents and performs no integrity check. The first sector that passes ends the search. The block then reports the sector's byte address and the length.

If every sector is blank or zero, the block reports that no image was found. It also raises a flag that tells the boot sequencer to move on to the next boot source. A one-cycle completion pulse marks the result in both cases.

Top module: `flash_image_locator`

## Requirements
- R1: Every probe sends, in SPI mode 0 with MSB first, the byte 0x03 followed by the 24-bit address, high byte first. In mode 0, SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the rising edge of SCLK. Chip select falls only while SCLK is low.
- R2: Sectors are 512 bytes. They are probed in the order 0x000000, 0x000200, 0x000400, 0x000600, each in its own chip-select-low window.
- R3: The length word is made from the four bytes that follow the address, in little-endian order: the first byte received becomes bits 7:0 and the fourth becomes bits 31:24.
- R4: A length word other than 0x00000000 and 0xFFFFFFFF accepts its sector. The result is then found=1, next-device=0, base address equal to the sector's byte address, and size equal to the length word.
- R5: After a sector is accepted, no later sector is probed.
- R6: If none of the four sectors is accepted, the result is found=0, next-device=1, and base and size both zero.
- R7: The done output is high for exactly one cycle per search. That cycle is the one in which the result outputs first show the new result. The results then hold until the next accepted start.
- R8: Between probes, chip select stays high for at least one full SCLK period (2*HALF_DIV clock cycles). SCLK is low whenever chip select is high.
- R9: A start pulse that arrives while a search is running is ignored. It does not restart, extend or repeat the search, and it does not produce an extra done pulse.
- R10: A synchronous active-high reset returns the block to idle within one cycle. After reset, chip select is high, SCLK is low, and done, found and next-device are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a search when the block is idle |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| found_o | output | 1 | An image header was accepted |
| base_addr_o | output | 24 | Byte address of the accepted sector |
| image_size_o | output | 32 | Length word of the accepted sector |
| next_dev_o | output | 1 | No sector accepted; try the next boot source |
| spi_sclk_o | output | 1 | SPI serial clock (mode 0) |
| spi_mosi_o | output | 1 | SPI data to the flash |
| spi_miso_i | input | 1 | SPI data from the flash |
| spi_csn_o | output | 1 | SPI chip select, active low |

## Verification
The search is tried with several patterns across the four length words:
- An image in the first sector shows that the search stops at once.
- Leading blank (all ones) and zero sectors before an image show that both rejection values are skipped.
- An image only in the last sector exercises the full walk.
- A flash with every sector rejected separates the next-device fallback from a real hit.

Boundary words just inside the reject values (0x00000001 and 0xFFFFFFFE) must be accepted. A word with four distinct bytes shows whether the bytes are assembled in the right order. A flash model attached to the pins records every command and address. With it, the probe order, the early stop, the opcode and the chip-select gap are all checked at the interface.

// File: rtl/flash_loc_pkg.sv
package flash_loc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_XFER,
    ST_GAP
  } loc_state_e;

  localparam logic [7:0] READ_OPCODE = 8'h03;
  localparam int         BYTE_W      = 8;
endpackage

// File: rtl/flash_loc_tick.sv
// Half-period strobe for the serial clock; restarts whenever disabled.
module flash_loc_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(HALF_DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_loc_shifter.sv
// One-byte mode-0 shift engine: MSB first, MISO sampled on SCLK rise.
module flash_loc_shifter
  import flash_loc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] tx,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx
);
  localparam int BW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [BW-1:0]     bitc;
  logic              busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      rx   <= '0;
      bitc <= '0;
      busy <= 1'b0;
      sclk <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh   <= tx;
        bitc <= '0;
        busy <= 1'b1;
        sclk <= 1'b0;
      end else if (busy && tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[BYTE_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitc == BW'(BYTE_W - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitc <= bitc + 1'b1;
            sh   <= {sh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi = sh[BYTE_W-1];
endmodule

// File: rtl/flash_loc_ctrl.sv
// Probe sequencer: walks sector starts, gathers the length word, decides.
module flash_loc_ctrl
  import flash_loc_pkg::*;
#(
  parameter int NUM_SECT   = 4,
  parameter int SECT_SHIFT = 9,
  parameter int ADDR_W     = 24,
  parameter int SIZE_W     = 32,
  parameter int GAP_TICKS  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic              sh_done,
  input  logic [BYTE_W-1:0] rx,
  output logic              load,
  output logic [BYTE_W-1:0] tx,
  output logic              csn,
  output logic              div_en,
  output logic              done,
  output logic              found,
  output logic [ADDR_W-1:0] base,
  output logic [SIZE_W-1:0] size,
  output logic              next_dev
);
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int CMD_BYTES  = 1 + ADDR_BYTES;
  localparam int DATA_BYTES = SIZE_W / BYTE_W;
  localparam int TOTAL      = CMD_BYTES + DATA_BYTES;
  localparam int IW         = $clog2(TOTAL + 1);
  localparam int SW         = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam int GW         = $clog2(GAP_TICKS + 1);

  loc_state_e        state;
  logic [IW-1:0]     issued;
  logic [SW-1:0]     sect;
  logic [GW-1:0]     gapc;
  logic [SIZE_W-1:0] word;
  logic [ADDR_W-1:0] probe_addr;
  logic              word_ok;

  assign probe_addr = ADDR_W'(sect) << SECT_SHIFT;
  assign word_ok    = (word != '0) && (word != '1);
  assign div_en     = (state != ST_IDLE);
  assign load       = ((state == ST_SELECT) && tick) ||
                      ((state == ST_XFER) && sh_done && (issued != IW'(TOTAL)));

  always_comb begin
    tx = '0;
    if (issued == '0)
      tx = READ_OPCODE;
    else if (int'(issued) < CMD_BYTES)
      tx = BYTE_W'(probe_addr >> (BYTE_W * (CMD_BYTES - 1 - int'(issued))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      issued   <= '0;
      sect     <= '0;
      gapc     <= '0;
      word     <= '0;
      csn      <= 1'b1;
      done     <= 1'b0;
      found    <= 1'b0;
      base     <= '0;
      size     <= '0;
      next_dev <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            found    <= 1'b0;
            next_dev <= 1'b0;
            base     <= '0;
            size     <= '0;
            sect     <= '0;
            issued   <= '0;
            csn      <= 1'b0;
            state    <= ST_SELECT;
          end
        end
        ST_SELECT: begin
          if (tick) begin
            issued <= issued + 1'b1;
            state  <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (sh_done) begin
            if (issued > IW'(CMD_BYTES))
              word <= {rx, word[SIZE_W-1:BYTE_W]};
            if (issued == IW'(TOTAL)) begin
              csn   <= 1'b1;
              gapc  <= '0;
              state <= ST_GAP;
            end else begin
              issued <= issued + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gapc == GW'(GAP_TICKS - 1)) begin
              if (word_ok) begin
                found <= 1'b1;
                base  <= probe_addr;
                size  <= word;
                done  <= 1'b1;
                state <= ST_IDLE;
              end else if (sect == SW'(NUM_SECT - 1)) begin
                next_dev <= 1'b1;
                done     <= 1'b1;
                state    <= ST_IDLE;
              end else begin
                sect   <= sect + 1'b1;
                issued <= '0;
                csn    <= 1'b0;
                state  <= ST_SELECT;
              end
            end else begin
              gapc <= gapc + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_image_locator.sv
module flash_image_locator
  import flash_loc_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int NUM_SECT   = 4,
  parameter int SECT_SHIFT = 9,
  parameter int ADDR_W     = 24,
  parameter int SIZE_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic [SIZE_W-1:0] image_size_o,
  output logic              next_dev_o,
  output logic              spi_sclk_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic              spi_csn_o
);
  // Three half-period ticks of deselect give at least one full SCLK period.
  localparam int GAP_TICKS = 3;

  logic              tick;
  logic              div_en;
  logic              load;
  logic              sh_done;
  logic [BYTE_W-1:0] tx_byte;
  logic [BYTE_W-1:0] rx_byte;

  flash_loc_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (div_en),
    .tick (tick)
  );

  flash_loc_shifter u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .tx   (tx_byte),
    .tick (tick),
    .miso (spi_miso_i),
    .sclk (spi_sclk_o),
    .mosi (spi_mosi_o),
    .done (sh_done),
    .rx   (rx_byte)
  );

  flash_loc_ctrl #(
    .NUM_SECT   (NUM_SECT),
    .SECT_SHIFT (SECT_SHIFT),
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .GAP_TICKS  (GAP_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .tick     (tick),
    .sh_done  (sh_done),
    .rx       (rx_byte),
    .load     (load),
    .tx       (tx_byte),
    .csn      (spi_csn_o),
    .div_en   (div_en),
    .done     (done_o),
    .found    (found_o),
    .base     (base_addr_o),
    .size     (image_size_o),
    .next_dev (next_dev_o)
  );
endmodule

// File: rtl/flash_loc_chk.sv
module flash_loc_chk #(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              done_o,
  input logic              found_o,
  input logic [ADDR_W-1:0] base_addr_o,
  input logic [SIZE_W-1:0] image_size_o,
  input logic              next_dev_o,
  input logic              spi_sclk_o,
  input logic              spi_mosi_o,
  input logic              spi_csn_o
);
  p_cs_fall_sclk_low_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_csn_o) |-> !spi_sclk_o);

  p_mosi_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk_o && $past(spi_sclk_o)) |-> $stable(spi_mosi_o));

  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (rst)
    spi_csn_o |-> !spi_sclk_o);

  p_base_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    found_o |-> (base_addr_o[8:0] == '0 && base_addr_o[ADDR_W-1:11] == '0));

  p_size_valid_r4: assert property (@(posedge clk) disable iff (rst)
    found_o |-> (image_size_o != '0 && image_size_o != '1));

  p_result_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (found_o != next_dev_o));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(found_o) || !$stable(image_size_o) || !$stable(next_dev_o))
      |-> (done_o || $past(start_i)));

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (spi_csn_o && !spi_sclk_o && !done_o && !found_o && !next_dev_o));
endmodule

bind flash_image_locator flash_loc_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .done_o       (done_o),
  .found_o      (found_o),
  .base_addr_o  (base_addr_o),
  .image_size_o (image_size_o),
  .next_dev_o   (next_dev_o),
  .spi_sclk_o   (spi_sclk_o),
  .spi_mosi_o   (spi_mosi_o),
  .spi_csn_o    (spi_csn_o)
);

// File: tb/flash_image_locator_tb_top.sv
module flash_image_locator_tb_top;
  localparam int HALF_DIV = 2;
  localparam int WAIT_MAX = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        miso = 1'b0;
  logic        done, found, next_dev, sclk, mosi, csn;
  logic [23:0] base;
  logic [31:0] size;

  always #4 clk = ~clk;

  flash_image_locator #(.HALF_DIV(HALF_DIV)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .done_o(done), .found_o(found),
    .base_addr_o(base), .image_size_o(size), .next_dev_o(next_dev),
    .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso), .spi_csn_o(csn)
  );

  int n_chk = 0;
  int n_fail = 0;

  // ---------------- flash model at the pins ----------------
  logic [31:0] sector_word [4];
  logic [31:0] hdr = '0;
  int          bitc = 0;
  int          probe_cnt = 0;
  logic [23:0] probe_addr [8];
  int          bad_cmd = 0;
  int          gap_cur = 0;
  int          gap_min = 1000000;
  int          done_cnt = 0;
  int          kk;
  logic [7:0]  fb;

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    if (a[23:11] == '0 && a[8:2] == '0)
      return sector_word[a[10:9]][8*int'(a[1:0]) +: 8];
    return 8'h5A;
  endfunction

  always @(negedge csn) begin
    if (probe_cnt > 0 && gap_cur < gap_min) gap_min = gap_cur;
    bitc = 0;
  end

  always @(posedge sclk) begin
    if (!csn) begin
      if (bitc < 32) hdr = {hdr[30:0], mosi};
      bitc = bitc + 1;
    end
  end

  always @(negedge sclk) begin
    if (!csn && bitc >= 32) begin
      kk   = bitc - 32;
      fb   = fbyte(hdr[23:0] + 24'(kk / 8));
      miso = fb[7 - (kk % 8)];
    end
  end

  always @(posedge csn) begin
    if (bitc >= 32) begin
      if (probe_cnt < 8) probe_addr[probe_cnt] = hdr[23:0];
      if (hdr[31:24] != 8'h03) bad_cmd = bad_cmd + 1;
      probe_cnt = probe_cnt + 1;
    end
    gap_cur = 0;
  end

  always @(posedge clk) begin
    if (csn) gap_cur = gap_cur + 1;
    if (done) done_cnt = done_cnt + 1;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    check(seen, req, "done seen", 64'(seen), 64'd1);
  endtask

  task automatic load_words(input logic [31:0] w0, w1, w2, w3);
    sector_word[0] = w0; sector_word[1] = w1;
    sector_word[2] = w2; sector_word[3] = w3;
  endtask

  task automatic run_search(input string req, input bit e_found, input logic [23:0] e_base,
                            input logic [31:0] e_size, input int e_probes);
    int d0;
    probe_cnt = 0;
    d0 = done_cnt;
    pulse_start();
    wait_done(req);
    check(found == e_found, req, "found", 64'(found), 64'(e_found));
    check(next_dev == !e_found, "R6", "next_dev", 64'(next_dev), 64'(!e_found));
    check(base == e_base, req, "base", 64'(base), 64'(e_base));
    check(size == e_size, req, "size", 64'(size), 64'(e_size));
    @(negedge clk);
    check(done == 1'b0, "R7", "done width", 64'(done), 64'd0);
    repeat (40) @(negedge clk);
    check(probe_cnt == e_probes, "R5", "probe count", 64'(probe_cnt), 64'(e_probes));
    for (int i = 0; i < e_probes && i < 8; i++)
      check(probe_addr[i] == 24'(i * 'h200), "R2", "probe address",
            64'(probe_addr[i]), 64'(i * 'h200));
    check(done_cnt - d0 == 1, "R7", "done pulses", 64'(done_cnt - d0), 64'd1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(csn && !sclk, "R10", "bus idle after reset", {62'd0, csn, sclk}, 64'b10);
    check(!done && !found && !next_dev, "R10", "outputs low after reset",
          {61'd0, done, found, next_dev}, 64'd0);
  endtask

  task automatic t_first_sector();   // R4 R5 R1
    load_words(32'h0000_6400, 32'h0000_1111, 32'h0000_2222, 32'h0000_3333);
    run_search("R4", 1'b1, 24'h000000, 32'h0000_6400, 1);
    check(bad_cmd == 0, "R1", "read opcode", 64'(bad_cmd), 64'd0);
  endtask

  task automatic t_byte_order();     // R3
    load_words(32'h0A0B_0C0D, 32'h0, 32'h0, 32'h0);
    run_search("R3", 1'b1, 24'h000000, 32'h0A0B_0C0D, 1);
  endtask

  task automatic t_skip_blank();     // R4 R5
    load_words(32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678, 32'h0000_0011);
    run_search("R5", 1'b1, 24'h000400, 32'h1234_5678, 3);
  endtask

  task automatic t_boundary();       // R4
    load_words(32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h5, 32'h5);
    run_search("R4", 1'b1, 24'h000200, 32'hFFFF_FFFE, 2);
    load_words(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001);
    run_search("R4", 1'b1, 24'h000600, 32'h0000_0001, 4);
  endtask

  task automatic t_none();           // R6
    load_words(32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000);
    run_search("R6", 1'b0, 24'h0, 32'h0, 4);
    check(bad_cmd == 0, "R1", "read opcode all probes", 64'(bad_cmd), 64'd0);
  endtask

  task automatic t_hold();           // R7
    logic [31:0] s0;
    load_words(32'h0, 32'h0000_0ABC, 32'h0, 32'h0);
    run_search("R4", 1'b1, 24'h000200, 32'h0000_0ABC, 2);
    s0 = size;
    repeat (200) @(negedge clk);
    check(found && size == s0 && base == 24'h200 && !done, "R7", "result hold",
          64'(size), 64'(s0));
  endtask

  task automatic t_busy_start();     // R9
    int d0;
    load_words(32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0777);
    probe_cnt = 0;
    d0 = done_cnt;
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();
    wait_done("R9");
    check(found && base == 24'h600, "R9", "result unchanged by start", 64'(base), 64'h600);
    repeat (1500) @(negedge clk);
    check(probe_cnt == 4, "R9", "probe count", 64'(probe_cnt), 64'd4);
    check(done_cnt - d0 == 1, "R9", "done pulses", 64'(done_cnt - d0), 64'd1);
    check(csn, "R9", "bus idle after search", 64'(csn), 64'd1);
  endtask

  task automatic t_gap();            // R8
    check(gap_min >= 2 * HALF_DIV, "R8", "deselect gap cycles",
          64'(gap_min), 64'(2 * HALF_DIV));
  endtask

  task automatic t_mid_reset();      // R10
    load_words(32'h0, 32'h0, 32'h0, 32'h0000_0042);
    pulse_start();
    repeat (250) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(csn && !sclk && !done && !found && !next_dev, "R10", "reset mid search",
          {59'd0, csn, sclk, done, found, next_dev}, 64'b10000);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    run_search("R10", 1'b1, 24'h000600, 32'h0000_0042, 4);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    load_words(32'h0, 32'h0, 32'h0, 32'h0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_sector();
    t_byte_order();
    t_skip_blank();
    t_boundary();
    t_none();
    t_hold();
    t_busy_start();
    t_gap();
    t_mid_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule